// File: doc/BRIEF.md
# Wake-Source Power Enable Controller

This block sequences board power by driving two enable lines toward an external regulator. The primary enable turns on when a permitted wake source fires. A wake source is a qualified edge on one of four wake pads, a one-cycle alarm pulse, or a one-cycle software wake pulse. The secondary enable has its own source mask. It can follow the primary enable, the alarm or the software pulse. Both enables stay on until a power-down request clears them.

Each pad level passes through a synchronizer before its edge is detected. The edge that counts as a wake depends on the pad's mode. The block keeps a one-hot wake-reason value, which changes only when the board goes from fully off to on. It also shows a live per-cycle event vector.

An optional record mode remembers a pad press made while power is already on. The next power-down then drops both enables for a single cycle and restores them at once.

Top module: `wake_pwr_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, both enables are low, the reason is zero and the event vector is zero.
- R2: Pads 0 and 1 wake on a rising edge and never on a falling edge. After the pad level changes ahead of a clock edge, the primary enable is still low after the second rising clock edge and is high after the third.
- R3: Pad 2 polarity is set by a 2-bit mode. Values 0 and 1 (dual compare) and 3 (high compare) wake on a rising edge. Value 2 (low compare) wakes on a falling edge only.
- R4: Pad 3 wakes on a rising edge when its pull-up select is 0, and on a falling edge only when it is 1.
- R5: The primary mask enables a source by bit: bit0 any pad event, bit1 alarm, bit2 software. A source whose bit is clear has no effect on the primary enable. Once on, the primary enable stays on until a power-down request.
- R6: The secondary mask enables a source by bit: bit0 the primary enable (rising in the same cycle as the primary), bit1 alarm, bit2 software. With mask value 2, the secondary enable ignores the primary enable.
- R7: A power-down request with nothing recorded leaves both enables low after the next clock edge. It takes priority over any wake event in the same cycle, and that event does not change the reason.
- R8: The reason is one-hot: bit0 to bit3 are pads 0 to 3, bit4 is the alarm and bit5 is software. It is loaded only when both enables were low and at least one turns on. Among simultaneous sources the lowest bit wins. At all other times it keeps its value.
- R9: The event vector uses the same bit positions as the reason. It shows the qualified pad edges and the alarm and software pulses of the current cycle, whatever the masks are set to.
- R10: In record mode, a pad event while the primary enable is on and primary mask bit0 is set gets latched. The next power-down request clears both enables for one cycle. In the following cycle the primary enable, and the secondary enable if its bit0 is set, return high, and the reason names the latched pad. With record mode off, such a press is ignored and the power-down is final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | 4 | Digitized wake pad levels, asynchronous |
| pad2_mode_i | input | 2 | Pad 2 compare mode (2 = falling edge, else rising) |
| pad3_pu_i | input | 1 | Pad 3 pull-up select (1 = falling edge) |
| en1_mask_i | input | 3 | Primary enable source mask |
| en2_mask_i | input | 3 | Secondary enable source mask |
| alarm_i | input | 1 | Alarm event, one-cycle pulse |
| sw_wake_i | input | 1 | Software wake, one-cycle pulse |
| rec_en_i | input | 1 | Record-mode enable for early presses |
| pd_req_i | input | 1 | Power-down request |
| pwr_en1_o | output | 1 | Primary power enable |
| pwr_en2_o | output | 1 | Secondary power enable |
| reason_o | output | 6 | One-hot wake reason |
| evt_o | output | 6 | Live per-cycle event vector |

## Verification
The assertions assume that the alarm and software inputs are single-cycle pulses that are already synchronous to the clock. They also assume that the pad mode, pull-up select and masks change only while a power-down request is held, so a reconfiguration cannot create a wake. The bench keeps within this. Every pattern first holds the power-down request while it sets masks, modes and idle pad levels, lets the synchronizer settle, and only then releases the request and moves one pad. The restore assertion is conditioned on the request dropping after one cycle, which is how the bench pulses it.

// File: rtl/wake_pwr_pkg.sv
package wake_pwr_pkg;
  localparam int unsigned NUM_PADS = 4;
  localparam int unsigned SRC_W    = NUM_PADS + 2;
  localparam int unsigned ALM_BIT  = NUM_PADS;
  localparam int unsigned SW_BIT   = NUM_PADS + 1;

  typedef enum logic [1:0] {
    P2_DUAL_A = 2'd0,
    P2_DUAL_B = 2'd1,
    P2_LOW    = 2'd2,
    P2_HIGH   = 2'd3
  } pad2_mode_e;

  // keep lowest set bit only
  function automatic logic [SRC_W-1:0] low_bit(input logic [SRC_W-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wake_edge.sv
module wake_edge #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign ev_o[i] = fall_i[i] ? (prev_q[i] & ~lvl_i[i])
                               : (~prev_q[i] & lvl_i[i]);
  end
endmodule

// File: rtl/wake_pwr_fsm.sv
module wake_pwr_fsm
  import wake_pwr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_ev_i,
  input  logic                alarm_i,
  input  logic                sw_i,
  input  logic [2:0]          m1_i,
  input  logic [2:0]          m2_i,
  input  logic                rec_en_i,
  input  logic                pd_i,
  output logic                en1_o,
  output logic                en2_o,
  output logic [SRC_W-1:0]    reason_o,
  output logic [NUM_PADS-1:0] pend_o
);
  logic                en1_q, en1_d, en2_q, en2_d;
  logic [SRC_W-1:0]    rsn_q, rsn_d;
  logic [NUM_PADS-1:0] pend_q, pend_d, redo_q, redo_d;
  logic                hit1, pad_any, was_off;
  logic [SRC_W-1:0]    qual, qual_pick, pad_pick;

  always_comb begin
    pad_any   = |pad_ev_i;
    hit1      = (m1_i[0] & pad_any) | (m1_i[1] & alarm_i) | (m1_i[2] & sw_i);
    qual      = {sw_i & (m1_i[2] | m2_i[2]),
                 alarm_i & (m1_i[1] | m2_i[1]),
                 pad_ev_i & {NUM_PADS{m1_i[0]}}};
    qual_pick = low_bit(qual);
    pad_pick  = low_bit({2'b00, pad_ev_i});
    was_off   = ~en1_q & ~en2_q;

    en1_d  = en1_q;
    en2_d  = en2_q;
    rsn_d  = rsn_q;
    pend_d = pend_q;
    redo_d = '0;

    if (pd_i) begin
      en1_d  = 1'b0;
      en2_d  = 1'b0;
      pend_d = '0;
      redo_d = pend_q;
    end else if (|redo_q) begin
      en1_d = 1'b1;
      en2_d = en2_q | m2_i[0];
      rsn_d = {2'b00, redo_q};
    end else begin
      en1_d = en1_q | hit1;
      en2_d = en2_q | (m2_i[0] & en1_d) | (m2_i[1] & alarm_i) | (m2_i[2] & sw_i);
      if (was_off && (en1_d || en2_d)) rsn_d = qual_pick;
      if (rec_en_i && en1_q && m1_i[0] && pad_any && (pend_q == '0))
        pend_d = pad_pick[NUM_PADS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en1_q  <= 1'b0;
      en2_q  <= 1'b0;
      rsn_q  <= '0;
      pend_q <= '0;
      redo_q <= '0;
    end else begin
      en1_q  <= en1_d;
      en2_q  <= en2_d;
      rsn_q  <= rsn_d;
      pend_q <= pend_d;
      redo_q <= redo_d;
    end
  end

  assign en1_o    = en1_q;
  assign en2_o    = en2_q;
  assign reason_o = rsn_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/wake_pwr_ctrl.sv
module wake_pwr_ctrl
  import wake_pwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       pad_i,
  input  logic [1:0]       pad2_mode_i,
  input  logic             pad3_pu_i,
  input  logic [2:0]       en1_mask_i,
  input  logic [2:0]       en2_mask_i,
  input  logic             alarm_i,
  input  logic             sw_wake_i,
  input  logic             rec_en_i,
  input  logic             pd_req_i,
  output logic             pwr_en1_o,
  output logic             pwr_en2_o,
  output logic [5:0]       reason_o,
  output logic [5:0]       evt_o
);
  logic [NUM_PADS-1:0] pad_s, fall_sel, pad_ev, pend_w;

  always_comb begin
    fall_sel    = '0;
    fall_sel[2] = (pad2_mode_e'(pad2_mode_i) == P2_LOW);
    fall_sel[3] = pad3_pu_i;
  end

  wake_sync #(.W(NUM_PADS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(pad_i), .q_o(pad_s)
  );

  wake_edge #(.W(NUM_PADS)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(pad_s), .fall_i(fall_sel), .ev_o(pad_ev)
  );

  wake_pwr_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .pad_ev_i(pad_ev), .alarm_i(alarm_i),
    .sw_i(sw_wake_i), .m1_i(en1_mask_i), .m2_i(en2_mask_i),
    .rec_en_i(rec_en_i), .pd_i(pd_req_i), .en1_o(pwr_en1_o),
    .en2_o(pwr_en2_o), .reason_o(reason_o), .pend_o(pend_w)
  );

  assign evt_o = {sw_wake_i, alarm_i, pad_ev};
endmodule

// File: rtl/wake_pwr_ctrl_chk.sv
module wake_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pd,
  input logic [2:0] m2,
  input logic       en1,
  input logic       en2,
  input logic [5:0] reason,
  input logic [3:0] pend
);
  p_pd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && pend == 4'd0) |=> (!en1 && !en2));

  p_reason_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reason));

  p_reason_only_from_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reason != $past(reason)) |-> (!$past(en1) && !$past(en2)));

  p_en2_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en2) |-> ($past(m2) != 3'd0));

  p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && pend != 4'd0) ##1 !pd |=> en1);

  p_pend_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend));
endmodule

bind wake_pwr_ctrl wake_pwr_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pd(pd_req_i), .m2(en2_mask_i),
  .en1(pwr_en1_o), .en2(pwr_en2_o), .reason(reason_o), .pend(pend_w)
);

// File: tb/wake_pwr_ctrl_tb_top.sv
module wake_pwr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {m1[3], m2[3], p2mode[2], p3pu[1], pad[2], fall[1], exp_en1, exp_en2, exp_reason[6]}
  localparam logic [19:0] VEC [NVEC] = '{
    {3'd1, 3'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 6'h01},
    {3'd1, 3'd0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 6'h02},
    {3'd1, 3'd1, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'h02},
    {3'd1, 3'd1, 2'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 6'h04},
    {3'd1, 3'd2, 2'd3, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 6'h04},
    {3'd1, 3'd1, 2'd2, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 6'h04},
    {3'd1, 3'd1, 2'd2, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 6'h04},
    {3'd1, 3'd1, 2'd1, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 6'h04},
    {3'd1, 3'd1, 2'd0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 6'h08},
    {3'd1, 3'd3, 2'd0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 6'h08},
    {3'd1, 3'd1, 2'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 6'h08},
    {3'd6, 3'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'h08},
    {3'd0, 3'd7, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 6'h08},
    {3'd1, 3'd5, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 6'h02}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] pad;
  logic [1:0] p2m;
  logic p3pu, alarm, sw, rec, pd;
  logic [2:0] m1, m2;
  logic en1, en2;
  logic [5:0] reason, evt;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_pwr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pad_i(pad), .pad2_mode_i(p2m), .pad3_pu_i(p3pu),
    .en1_mask_i(m1), .en2_mask_i(m2), .alarm_i(alarm), .sw_wake_i(sw),
    .rec_en_i(rec), .pd_req_i(pd), .pwr_en1_o(en1), .pwr_en2_o(en2),
    .reason_o(reason), .evt_o(evt)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // hold power-down while reconfiguring, then release
  task automatic setup(input logic [2:0] a, input logic [2:0] b, input logic [1:0] md,
                       input logic pu, input logic [3:0] idle);
    @(negedge clk);
    pd = 1'b1; alarm = 1'b0; sw = 1'b0;
    m1 = a; m2 = b; p2m = md; p3pu = pu; pad = idle;
    cyc(5);
    pd = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pad = '0; p2m = '0; p3pu = 1'b0; alarm = 1'b0; sw = 1'b0;
    rec = 1'b0; pd = 1'b0; m1 = 3'd0; m2 = 3'd0;
    cyc(3);
    chk("R1 en1 in reset", {7'd0, en1}, 8'd0);
    chk("R1 en2 in reset", {7'd0, en2}, 8'd0);
    chk("R1 reason in reset", {2'd0, reason}, 8'd0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 after release", {2'd0, evt}, 8'd0);
    chk("R1 reason after release", {2'd0, reason}, 8'd0);

    // table walk (R2 R3 R4 R5 R6 R8)
    for (int v = 0; v < NVEC; v++) begin
      logic [19:0] e;
      logic [3:0] idle;
      e = VEC[v];
      idle = '0;
      idle[e[10:9]] = e[8];
      setup(e[19:17], e[16:14], e[13:12], e[11], idle);
      pad[e[10:9]] = ~e[8];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5 vec%0d en1", v), {7'd0, en1}, {7'd0, e[7]});
      chk($sformatf("R6 vec%0d en2", v), {7'd0, en2}, {7'd0, e[6]});
      chk($sformatf("R8 vec%0d reason", v), {2'd0, reason}, {2'd0, e[5:0]});
    end

    // R2 latency and R9 live status
    setup(3'd1, 3'd0, 2'd0, 1'b0, 4'h0);
    pad[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 not yet after two edges", {7'd0, en1}, 8'd0);
    chk("R9 event vector pad0", {2'd0, evt}, 8'h01);
    cyc(1);
    chk("R2 high after third edge", {7'd0, en1}, 8'd1);
    setup(3'd0, 3'd0, 2'd0, 1'b0, 4'h0);
    pad[1] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 event vector with masks off", {2'd0, evt}, 8'h02);
    chk("R5 masked pad no effect", {7'd0, en1}, 8'd0);

    // alarm and software sources
    setup(3'd2, 3'd0, 2'd0, 1'b0, 4'h0);
    alarm = 1'b1; cyc(1); alarm = 1'b0;
    chk("R5 alarm drives en1", {6'd0, en2, en1}, 8'd1);
    chk("R8 alarm reason", {2'd0, reason}, 8'h10);
    sw = 1'b1; cyc(1); sw = 1'b0;
    chk("R8 reason kept while on", {2'd0, reason}, 8'h10);
    setup(3'd0, 3'd2, 2'd0, 1'b0, 4'h0);
    alarm = 1'b1; cyc(1); alarm = 1'b0;
    chk("R6 alarm drives en2 only", {6'd0, en2, en1}, 8'd2);
    setup(3'd4, 3'd4, 2'd0, 1'b0, 4'h0);
    sw = 1'b1; cyc(1); sw = 1'b0;
    chk("R5 software drives both", {6'd0, en2, en1}, 8'd3);
    chk("R8 software reason", {2'd0, reason}, 8'h20);
    setup(3'd7, 3'd0, 2'd0, 1'b0, 4'h0);
    alarm = 1'b1; sw = 1'b1; cyc(1); alarm = 1'b0; sw = 1'b0;
    chk("R8 lowest bit wins", {2'd0, reason}, 8'h10);

    // R7 priority of power-down
    setup(3'd4, 3'd4, 2'd0, 1'b0, 4'h0);
    sw = 1'b1; pd = 1'b1; cyc(1); sw = 1'b0; pd = 1'b0;
    chk("R7 power-down wins over wake", {6'd0, en2, en1}, 8'd0);
    chk("R7 reason untouched", {2'd0, reason}, 8'h10);
    sw = 1'b1; cyc(1); sw = 1'b0;
    pd = 1'b1; cyc(1); pd = 1'b0;
    chk("R7 power-down clears", {6'd0, en2, en1}, 8'd0);

    // R10 record mode
    setup(3'd3, 3'd1, 2'd0, 1'b0, 4'h0);
    rec = 1'b1;
    alarm = 1'b1; cyc(1); alarm = 1'b0;
    chk("R10 on by alarm", {2'd0, reason}, 8'h10);
    pad[1] = 1'b1;
    cyc(4);
    pd = 1'b1; cyc(1); pd = 1'b0;
    chk("R10 off for one cycle", {6'd0, en2, en1}, 8'd0);
    cyc(1);
    chk("R10 restored", {6'd0, en2, en1}, 8'd3);
    chk("R10 reason names latched pad", {2'd0, reason}, 8'h02);
    rec = 1'b0;
    pad[0] = 1'b1;
    cyc(4);
    pd = 1'b1; cyc(1); pd = 1'b0;
    cyc(2);
    chk("R10 no record: power-down final", {6'd0, en2, en1}, 8'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule